// File: doc/BRIEF.md
# Memory Device Test Access Port

This block is the boundary-scan test port of a memory device. A serial test controller steps a sixteen-state controller with a mode-select line sampled on the rising test clock. In its shift states the port moves serial data through one of four registers: a 3-bit instruction register, a 1-bit bypass cell, a 32-bit identifier register, or a boundary register that snapshots the device pin levels. Serial output changes on the falling test clock edge and is enabled only while shifting.

The instruction set has five public codes and three private codes. One public code samples the pins and also holds a control line high that forces the device's functional data drivers off while that instruction is active. The identifier value, the boundary length and the position of one boundary place-holder cell, which always captures zero, are parameters.

Top module: `scan_port`

## Requirements
- R1: The controller is in Test-Logic-Reset after power-on reset (`por_n` low). From any state, five consecutive rising test clock edges with `tms` high bring it to Test-Logic-Reset. All other transitions follow the standard sixteen-state test controller graph, including Pause-DR and Exit2-DR back to Shift-DR.
- R2: `tdo` and `tdo_oe` update on the falling `tck` edge. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR. Each shifted bit appears on `tdo` from the falling edge in the shift state, with the register's bit 0 first.
- R3: The active instruction is the identifier code 3'b001 after power-on and after Test-Logic-Reset. Capture-IR loads 3'b001, so the first three bits shifted out of the instruction register are 1, 0, 0.
- R4: An instruction shifted into the instruction register becomes active only at the rising edge that leaves Update-IR. Until then the previous instruction stays in effect.
- R5: Codes 3'b000 and 3'b111 select the bypass cell. The private codes 3'b011, 3'b101 and 3'b110 also select the bypass cell. Code 3'b001 selects the identifier register. Codes 3'b010 and 3'b100 select the boundary register.
- R6: The bypass cell captures 0 in Capture-DR. Data on `tdi` appears on `tdo` exactly one shift later.
- R7: With the identifier instruction active, Capture-DR loads parameter `ID_VALUE`. Its default is {4'h2, 16'h00A5, 11'h35A, 1'b1}: revision in bits 31:28, part number in bits 27:12, maker code in bits 11:1, and 1 in bit 0. After 32 shifts, `tdi` bits follow on `tdo`.
- R8: With either sampling instruction active, Capture-DR loads `pins_in` into the `BS_LEN`-bit boundary register (default 70). The cell at index `HOLE_IDX` (default 54) always captures 0. Index 0 leaves first on `tdo`. `tdi` enters at the top, and after `BS_LEN` shifts, `tdi` bits follow on `tdo`.
- R9: `dq_off` is 1 exactly while 3'b010 is the active instruction, and 0 under every other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pins_in | input | BS_LEN | Parallel device pin levels for boundary capture |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Serial output enable, high in shift states |
| dq_off | output | 1 | Forces functional data drivers off |

## Verification
Capture happens at the rising edge that leaves Capture-IR or Capture-DR. The first captured bit is on `tdo` at the falling edge that follows, so the bench samples `tdo` one nanosecond after each falling edge, before it drives the next `tms`/`tdi` pair. `dq_off` changes at the rising edge that leaves Update-IR. It is sampled once while the controller still sits in Update-IR, where it must hold the old value, and once after that edge. After five high `tms` edges the reset of the instruction takes effect one edge after Test-Logic-Reset is entered, and the check is placed there. Expected serial streams are built by a bench function from the opcode, the pin pattern and the shifted-in data.

// File: rtl/scan_port.sv
module scan_port #(
  parameter int          BS_LEN   = 70,
  parameter int          HOLE_IDX = 54,
  parameter logic [31:0] ID_VALUE = {4'h2, 16'h00A5, 11'h35A, 1'b1}
) (
  input  logic              tck,
  input  logic              por_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic [BS_LEN-1:0] pins_in,
  output logic              tdo,
  output logic              tdo_oe,
  output logic              dq_off
);
  localparam logic [2:0] OP_IDCODE = 3'b001;
  localparam logic [2:0] OP_SAMPZ  = 3'b010;
  localparam logic [2:0] OP_SAMPLE = 3'b100;
  localparam logic [BS_LEN-1:0] HOLE_MASK = ~({{(BS_LEN-1){1'b0}}, 1'b1} << HOLE_IDX);

  typedef enum logic [3:0] {
    S_TLR, S_IDLE, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_st_e;

  tap_st_e state_q, state_d;
  logic [2:0]        ir_q, ir_sr;
  logic              byp_q;
  logic [31:0]       id_sr;
  logic [BS_LEN-1:0] bs_sr;

  always_comb begin
    case (state_q)
      S_TLR:    state_d = tms ? S_TLR    : S_IDLE;
      S_IDLE:   state_d = tms ? S_SEL_DR : S_IDLE;
      S_SEL_DR: state_d = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: state_d = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  state_d = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: state_d = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: state_d = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: state_d = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: state_d = tms ? S_SEL_DR : S_IDLE;
      S_SEL_IR: state_d = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: state_d = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  state_d = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: state_d = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: state_d = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: state_d = tms ? S_UPD_IR : S_SH_IR;
      default:  state_d = tms ? S_SEL_DR : S_IDLE;
    endcase
  end

  wire sel_id = (ir_q == OP_IDCODE);
  wire sel_bs = (ir_q == OP_SAMPZ) || (ir_q == OP_SAMPLE);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      state_q <= S_TLR;
      ir_q    <= OP_IDCODE;
      ir_sr   <= OP_IDCODE;
      byp_q   <= 1'b0;
      id_sr   <= '0;
      bs_sr   <= '0;
    end else begin
      state_q <= state_d;
      case (state_q)
        S_TLR: begin
          ir_q  <= OP_IDCODE;
          ir_sr <= OP_IDCODE;
        end
        S_CAP_IR: ir_sr <= OP_IDCODE;
        S_SH_IR:  ir_sr <= {tdi, ir_sr[2:1]};
        S_UPD_IR: ir_q  <= ir_sr;
        S_CAP_DR: begin
          if (sel_id)      id_sr <= ID_VALUE;
          else if (sel_bs) bs_sr <= pins_in & HOLE_MASK;
          else             byp_q <= 1'b0;
        end
        S_SH_DR: begin
          if (sel_id)      id_sr <= {tdi, id_sr[31:1]};
          else if (sel_bs) bs_sr <= {tdi, bs_sr[BS_LEN-1:1]};
          else             byp_q <= tdi;
        end
        default: ;
      endcase
    end
  end

  wire dr_lsb = sel_id ? id_sr[0] : (sel_bs ? bs_sr[0] : byp_q);

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state_q == S_SH_IR) || (state_q == S_SH_DR);
      if (state_q == S_SH_IR)      tdo <= ir_sr[0];
      else if (state_q == S_SH_DR) tdo <= dr_lsb;
    end
  end

  assign dq_off = (ir_q == OP_SAMPZ);
endmodule

module scan_port_chk (
  input logic tck,
  input logic por_n,
  input logic tms,
  input logic tdo_oe,
  input logic dq_off,
  input logic upd_ir,
  input logic shifting,
  input logic tlr
);
  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                    ones_q <= '0;
    else if (!tms)                 ones_q <= '0;
    else if (ones_q != 3'd7)       ones_q <= ones_q + 3'd1;
  end

  p_five_ones_r1: assert property (@(posedge tck) disable iff (!por_n)
    (ones_q >= 3'd5) |-> tlr);
  p_oe_shift_only_r2: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe == shifting);
  p_tlr_quiet_r2: assert property (@(posedge tck) disable iff (!por_n)
    tlr |-> !tdo_oe);
  p_ir_reset_r3: assert property (@(posedge tck) disable iff (!por_n)
    $past(tlr) |-> !dq_off);
  p_update_only_r4: assert property (@(posedge tck) disable iff (!por_n)
    !$stable(dq_off) |-> ($past(upd_ir) || $past(tlr)));
endmodule

bind scan_port scan_port_chk u_chk (
  .tck(tck), .por_n(por_n), .tms(tms), .tdo_oe(tdo_oe), .dq_off(dq_off),
  .upd_ir(state_q == S_UPD_IR),
  .shifting((state_q == S_SH_IR) || (state_q == S_SH_DR)),
  .tlr(state_q == S_TLR)
);

// File: tb/scan_port_bench.sv
`timescale 1ns/100ps
module scan_port_bench;
  localparam int          BLEN = 70;
  localparam int          HOLE = 54;
  localparam logic [31:0] IDV  = {4'h2, 16'h00A5, 11'h35A, 1'b1};

  logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [BLEN-1:0] pins = '0;
  logic tdo, tdo_oe, dq_off;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 tck = ~tck;

  scan_port u_scan_port (.tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pins_in(pins),
                         .tdo(tdo), .tdo_oe(tdo_oe), .dq_off(dq_off));

  task automatic check(input logic [127:0] act, input logic [127:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  function automatic logic [127:0] exp_dr(input logic [2:0] op, input logic [BLEN-1:0] p,
                                          input logic [127:0] din, input int n);
    logic [127:0] cap, r;
    int len;
    cap = '0; r = '0;
    if (op == 3'b001) begin cap[31:0] = IDV; len = 32; end
    else if (op == 3'b010 || op == 3'b100) begin
      cap[BLEN-1:0] = p; cap[HOLE] = 1'b0; len = BLEN;
    end else len = 1;
    for (int i = 0; i < n; i++) r[i] = (i < len) ? cap[i] : din[i-len];
    return r;
  endfunction

  task automatic shift_ir(input logic [2:0] op, input logic exp_old);
    logic [2:0] o;
    step(1,0); step(1,0); step(0,0); step(0,0);
    for (int i = 0; i < 3; i++) begin o[i] = tdo; step(i == 2, op[i]); end
    check({125'd0, o}, 128'd1, "R3 capture-IR pattern");
    step(1,0);
    check({127'd0, dq_off}, {127'd0, exp_old}, "R4 old instruction held in Update-IR");
    step(0,0);
    check({127'd0, dq_off}, {127'd0, op == 3'b010}, "R9 dq_off after update");
  endtask

  task automatic shift_dr(input int n, input logic [127:0] din, output logic [127:0] dout);
    dout = '0;
    step(1,0); step(0,0); step(0,0);
    check({127'd0, tdo_oe}, 128'd1, "R2 tdo_oe in Shift-DR");
    for (int i = 0; i < n; i++) begin dout[i] = tdo; step(i == n-1, din[i]); end
    check({127'd0, tdo_oe}, 128'd0, "R2 tdo_oe off in Exit1-DR");
    step(1,0); step(0,0);
  endtask

  initial begin
    logic [127:0] o, din;
    logic [95:0]  rr;
    logic [2:0]   op, cur;
    void'($urandom(32'd20240611));
    #9 por_n = 1'b1;
    @(negedge tck); #1;
    check({126'd0, tdo_oe, dq_off}, 128'd0, "R1 reset outputs quiet");
    step(0,0);
    check({127'd0, tdo_oe}, 128'd0, "R2 no drive in Idle");
    shift_dr(40, 128'hAB, o);
    check(o[39:0], exp_dr(3'b001, pins, 128'hAB, 40), "R7 power-up IDCODE");

    shift_ir(3'b000, 1'b0);
    shift_dr(8, 128'hB5, o);
    check(o[7:0], {8'hB5 << 1}, "R6 bypass one-shift delay");
    shift_ir(3'b111, 1'b0);
    shift_dr(8, 128'h3C, o);
    check(o[7:0], 8'h78, "R5 code 111 bypass");
    shift_ir(3'b101, 1'b0);
    shift_dr(4, 128'h9, o);
    check(o[3:0], 4'h2, "R5 private code bypass");

    pins = '1;
    shift_ir(3'b100, 1'b0);
    shift_dr(BLEN+4, 128'hA, o);
    check(o, exp_dr(3'b100, pins, 128'hA, BLEN+4), "R8 boundary all ones with hole");
    check({127'd0, o[HOLE]}, 128'd0, "R8 place-holder captures 0");

    shift_ir(3'b010, 1'b0);
    check({127'd0, dq_off}, 128'd1, "R9 sample-z drives dq_off");
    step(1,0); step(0,0); step(0,0);
    for (int i = 0; i < 5; i++) step(1,0);
    check({127'd0, tdo_oe}, 128'd0, "R1 five ones reach reset");
    step(0,0);
    check({127'd0, dq_off}, 128'd0, "R3 reset restores IDCODE");
    shift_dr(32, 128'd0, o);
    check(o[31:0], IDV, "R3 IDCODE active after reset");

    step(1,0); step(0,0); step(0,0);
    for (int i = 0; i < 10; i++) begin o[i] = tdo; step(i == 9, 1'b0); end
    step(0,0);
    check({127'd0, tdo_oe}, 128'd0, "R2 no drive in Pause-DR");
    step(1,0); step(0,0);
    for (int i = 10; i < 32; i++) begin o[i] = tdo; step(i == 31, 1'b0); end
    step(1,0); step(0,0);
    check(o[31:0], IDV, "R1 pause and resume shift");

    cur = 3'b001;
    for (int k = 0; k < 40; k++) begin
      op = 3'($urandom_range(0, 7));
      rr = {$urandom(), $urandom(), $urandom()};
      pins = rr[BLEN-1:0];
      din = {$urandom(), $urandom(), $urandom(), $urandom()};
      shift_ir(op, cur == 3'b010);
      cur = op;
      shift_dr(BLEN+10, din, o);
      check(o, exp_dr(op, pins, din, BLEN+10), "R5 random opcode scan");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule